// File: doc/BRIEF.md
# Processor-driven FIFO byte port

This block lets the host processor move bytes in and out of the controller's FIFOs one access at a time, with no bus-master engine. A single port accepts 8-bit or 16-bit accesses. A mode input picks the destination. When it is high, the traffic goes to a command FIFO. When it is low, the traffic goes to the data FIFO. Every written byte consumes one count from a 24-bit transfer counter, which the sequencer loads. When the counter reaches zero, further writes are dropped.

The block raises a one-cycle completion pulse when the transfer should return control to the sequencer. After a write, the pulse fires when the counter is exhausted or the data FIFO is full. After a read, it fires when the data FIFO is empty. A data-request output tells the host that the sequencer wants a transfer. The block also models a sequencer side, so the FIFOs can be filled and drained: a one-byte push into the data FIFO and a one-byte pop from the selected FIFO.

Top module: `pdma_byte_port`

## Requirements
- R1: An 8-bit write (`acc_wide`=0) with a nonzero counter pushes `wr_data[7:0]` into the selected FIFO and lowers `tc_value` by one. The new value is visible after the clock edge that accepts the write.
- R2: A 16-bit write (`acc_wide`=1) enqueues `wr_data[15:8]` before `wr_data[7:0]`. Each byte accepted lowers the counter by one.
- R3: A byte offered while the counter is zero is discarded. The FIFO and the counter stay unchanged. In a 16-bit write with the counter at 1, only the high byte is taken.
- R4: When `cmd_mode`=1, host writes, host reads and sequencer pops use the command FIFO (32 bytes). When `cmd_mode`=0, they use the data FIFO (16 bytes).
- R5: `done_pulse` is high for the single cycle after any write. It is high only if, after the write, the counter is zero or the data FIFO holds 16 bytes.
- R6: A 16-bit read returns the first byte dequeued in `rd_data[15:8]` and the second in `rd_data[7:0]`. An 8-bit read returns its byte in `rd_data[7:0]` with the upper byte zero. `rd_data` is valid after the accepting edge.
- R7: `done_pulse` is high for the single cycle after any read. It is high only if the data FIFO is empty after that read.
- R8: A pop from an empty FIFO returns 0x00. A push into a full FIFO is dropped, but the counter still decrements for that byte.
- R9: `drq` rises on the edge after `xfer_req` is high. `drq` falls on the edge that ends a `done_pulse`, unless `xfer_req` is high at that edge, in which case the request wins.
- R10: `tc_load` copies `tc_load_val` into the counter, except in a cycle with a host write, where the load is ignored. A host write has priority over a host read in the same cycle. Sequencer push and pop are ignored in any cycle with a host access.
- R11: After reset the counter is 0, both FIFOs are empty, and `drq`, `done_pulse` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mode | input | 1 | 1 selects the command FIFO, 0 the data FIFO |
| wr_en | input | 1 | Host write access strobe |
| rd_en | input | 1 | Host read access strobe |
| acc_wide | input | 1 | 1 for a 16-bit access, 0 for 8-bit |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Host read data, registered |
| tc_load | input | 1 | Sequencer counter load strobe |
| tc_load_val | input | 24 | Value loaded into the counter |
| tc_value | output | 24 | Current transfer counter |
| xfer_req | input | 1 | Sequencer asks for a host transfer |
| drq | output | 1 | Data request to the host |
| done_pulse | output | 1 | One-cycle completion pulse |
| seq_push | input | 1 | Sequencer pushes one byte into the data FIFO |
| seq_push_data | input | 8 | Byte pushed by the sequencer |
| seq_pop | input | 1 | Sequencer pops one byte from the selected FIFO |
| seq_pop_data | output | 8 | Head of the selected FIFO, 0 when empty |
| data_level | output | 5 | Bytes held in the data FIFO |
| cmd_level | output | 6 | Bytes held in the command FIFO |

## Verification
Some properties are checked on every cycle:
- the counter stepping down by one on a narrow write;
- a write with the counter at zero leaving the counter at zero;
- the completion pulse agreeing with the post-access counter and data-FIFO level, and appearing only after an access;
- data-mode writes never touching the command FIFO;
- the request flag following its set and clear rules;
- a load landing only when no write competes;
- the FIFO levels staying within bounds.

Byte order inside the FIFOs, the packing of 16-bit reads, the zero returned by an empty pop, and overflow with the counter still counting all need the bench's directed sequences. In those sequences the bytes are drained and compared with the values written.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  // Which FIFO a host or sequencer access is steered to.
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CMD  = 1'b1
  } fifo_sel_e;

  // Bytes carried by one host access.
  function automatic logic [1:0] access_bytes(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

  // Order of bytes on the write path: big-endian for a pair.
  function automatic logic [7:0] first_wr_byte(input logic wide, input logic [15:0] d);
    return wide ? d[15:8] : d[7:0];
  endfunction

  // Packing of popped bytes into the host read word.
  function automatic logic [15:0] pack_read(input logic wide,
                                            input logic [7:0] b_first,
                                            input logic [7:0] b_second);
    return wide ? {b_first, b_second} : {8'h00, b_first};
  endfunction

endpackage

// File: rtl/pdma_byte_fifo.sv
// Byte FIFO taking up to two pushes and two pops per cycle.
// DEPTH must be a power of two; pointers wrap naturally.
module pdma_byte_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_cnt,
  input  logic [7:0]    push_b0,
  input  logic [7:0]    push_b1,
  input  logic [1:0]    pop_cnt,
  output logic [7:0]    head0,
  output logic [7:0]    head1,
  output logic [CW-1:0] level,
  output logic          full_nxt,
  output logic          empty_nxt
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, count_nxt, room;
  logic [1:0]    pop_ok, push_ok;

  function automatic logic [1:0] clip2(input logic [1:0] want, input logic [CW-1:0] avail);
    if (CW'(want) > avail) return avail[1:0];
    return want;
  endfunction

  always_comb begin
    pop_ok    = clip2(pop_cnt, count);
    room      = CW'(DEPTH) - (count - CW'(pop_ok));
    push_ok   = clip2(push_cnt, room);
    count_nxt = count - CW'(pop_ok) + CW'(push_ok);
    full_nxt  = (count_nxt == CW'(DEPTH));
    empty_nxt = (count_nxt == '0);
  end

  assign head0 = (count >= CW'(1)) ? mem[rd_ptr] : 8'h00;
  assign head1 = (count >= CW'(2)) ? mem[rd_ptr + AW'(1)] : 8'h00;
  assign level = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_ok);
      rd_ptr <= rd_ptr + AW'(pop_ok);
      count  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok != 2'd0) mem[wr_ptr] <= push_b0;
    if (push_ok == 2'd2) mem[wr_ptr + AW'(1)] <= push_b1;
  end

endmodule

// File: rtl/pdma_xfer_counter.sv
// Shared transfer counter: loaded by the sequencer, consumed by host writes.
module pdma_xfer_counter #(
  parameter int TCW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_req,
  input  logic           wr_wide,
  input  logic           load,
  input  logic [TCW-1:0] load_val,
  output logic [1:0]     take,
  output logic [TCW-1:0] tc,
  output logic           tc_zero_nxt
);

  logic [TCW-1:0] tc_nxt;

  // Bytes a write may consume: the request, clipped by what is left.
  function automatic logic [1:0] bytes_allowed(input logic [TCW-1:0] left, input logic wide);
    logic [1:0] want;
    want = pdma_pkg::access_bytes(wide);
    if (left < TCW'(want)) return left[1:0];
    return want;
  endfunction

  always_comb begin
    take   = wr_req ? bytes_allowed(tc, wr_wide) : 2'd0;
    if (wr_req)    tc_nxt = tc - TCW'(take);
    else if (load) tc_nxt = load_val;
    else           tc_nxt = tc;
    tc_zero_nxt = (tc_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc <= '0;
    else        tc <= tc_nxt;
  end

endmodule

// File: rtl/pdma_handshake.sv
// Completion pulse and data-request flag.
module pdma_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic host_rd,
  input  logic wr_finish,
  input  logic rd_finish,
  input  logic xfer_req,
  output logic done_pulse,
  output logic drq
);

  logic finish_now;

  always_comb begin
    finish_now = 1'b0;
    if (host_wr)      finish_now = wr_finish;
    else if (host_rd) finish_now = rd_finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse <= 1'b0;
      drq        <= 1'b0;
    end else begin
      done_pulse <= finish_now;
      drq        <= xfer_req | (drq & ~done_pulse);
    end
  end

endmodule

// File: rtl/pdma_byte_port.sv
module pdma_byte_port #(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  parameter int TCW        = 24,
  localparam int DLW = $clog2(DATA_DEPTH) + 1,
  localparam int CLW = $clog2(CMD_DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_mode,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic           acc_wide,
  input  logic [15:0]    wr_data,
  output logic [15:0]    rd_data,
  input  logic           tc_load,
  input  logic [TCW-1:0] tc_load_val,
  output logic [TCW-1:0] tc_value,
  input  logic           xfer_req,
  output logic           drq,
  output logic           done_pulse,
  input  logic           seq_push,
  input  logic [7:0]     seq_push_data,
  input  logic           seq_pop,
  output logic [7:0]     seq_pop_data,
  output logic [DLW-1:0] data_level,
  output logic [CLW-1:0] cmd_level
);
  import pdma_pkg::*;

  // Named internal events.
  logic       host_wr, host_rd, host_any;
  logic       seq_push_ok, seq_pop_ok;
  fifo_sel_e  sel;
  logic [1:0] wr_take;
  logic       tc_zero_nxt;

  logic [1:0] d_push_cnt, d_pop_cnt, c_push_cnt, c_pop_cnt;
  logic [7:0] d_push_b0, c_push_b0, wr_b0, wr_b1;
  logic [7:0] d_head0, d_head1, c_head0, c_head1;
  logic [7:0] sel_head0, sel_head1;
  logic       d_full_nxt, d_empty_nxt, c_full_nxt, c_empty_nxt;
  logic [1:0] rd_cnt;

  assign host_wr     = wr_en;
  assign host_rd     = rd_en & ~wr_en;
  assign host_any    = host_wr | host_rd;
  assign seq_push_ok = seq_push & ~host_any;
  assign seq_pop_ok  = seq_pop & ~host_any;
  assign sel         = cmd_mode ? SEL_CMD : SEL_DATA;
  assign wr_b0       = first_wr_byte(acc_wide, wr_data);
  assign wr_b1       = wr_data[7:0];
  assign rd_cnt      = host_rd ? access_bytes(acc_wide) : (seq_pop_ok ? 2'd1 : 2'd0);

  always_comb begin
    d_push_cnt = 2'd0;
    d_push_b0  = wr_b0;
    c_push_cnt = 2'd0;
    c_push_b0  = wr_b0;
    d_pop_cnt  = 2'd0;
    c_pop_cnt  = 2'd0;
    if (host_wr) begin
      if (sel == SEL_CMD) c_push_cnt = wr_take;
      else                d_push_cnt = wr_take;
    end else if (seq_push_ok) begin
      d_push_cnt = 2'd1;
      d_push_b0  = seq_push_data;
    end
    if (sel == SEL_CMD) c_pop_cnt = rd_cnt;
    else                d_pop_cnt = rd_cnt;
  end

  assign sel_head0    = (sel == SEL_CMD) ? c_head0 : d_head0;
  assign sel_head1    = (sel == SEL_CMD) ? c_head1 : d_head1;
  assign seq_pop_data = sel_head0;

  pdma_xfer_counter #(.TCW(TCW)) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (host_wr),
    .wr_wide     (acc_wide),
    .load        (tc_load),
    .load_val    (tc_load_val),
    .take        (wr_take),
    .tc          (tc_value),
    .tc_zero_nxt (tc_zero_nxt)
  );

  pdma_byte_fifo #(.DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_cnt  (d_push_cnt),
    .push_b0   (d_push_b0),
    .push_b1   (wr_b1),
    .pop_cnt   (d_pop_cnt),
    .head0     (d_head0),
    .head1     (d_head1),
    .level     (data_level),
    .full_nxt  (d_full_nxt),
    .empty_nxt (d_empty_nxt)
  );

  pdma_byte_fifo #(.DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_cnt  (c_push_cnt),
    .push_b0   (c_push_b0),
    .push_b1   (wr_b1),
    .pop_cnt   (c_pop_cnt),
    .head0     (c_head0),
    .head1     (c_head1),
    .level     (cmd_level),
    .full_nxt  (c_full_nxt),
    .empty_nxt (c_empty_nxt)
  );

  pdma_handshake u_handshake (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .wr_finish  (tc_zero_nxt | d_full_nxt),
    .rd_finish  (d_empty_nxt),
    .xfer_req   (xfer_req),
    .done_pulse (done_pulse),
    .drq        (drq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (host_rd) rd_data <= pack_read(acc_wide, sel_head0, sel_head1);
  end

endmodule

// File: rtl/pdma_byte_port_chk.sv
module pdma_byte_port_chk #(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  parameter int TCW        = 24,
  localparam int DLW = $clog2(DATA_DEPTH) + 1,
  localparam int CLW = $clog2(CMD_DEPTH) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_mode,
  input logic           host_wr,
  input logic           host_rd,
  input logic           acc_wide,
  input logic           tc_load,
  input logic [TCW-1:0] tc_load_val,
  input logic [TCW-1:0] tc_value,
  input logic           xfer_req,
  input logic           drq,
  input logic           done_pulse,
  input logic [DLW-1:0] data_level,
  input logic [CLW-1:0] cmd_level
);

  a_r1_narrow_step: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !acc_wide && tc_value != '0 |=> tc_value == $past(tc_value) - TCW'(1));

  a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && tc_value == '0 |=> tc_value == '0);

  a_r4_data_route: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !cmd_mode |=> $stable(cmd_level));

  a_r5_wr_finish: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> done_pulse == (tc_value == '0 || data_level == DLW'(DATA_DEPTH)));

  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr || host_rd) |=> !done_pulse);

  a_r7_rd_finish: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> done_pulse == (data_level == '0));

  a_r8_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    data_level <= DLW'(DATA_DEPTH) && cmd_level <= CLW'(CMD_DEPTH));

  a_r9_drq_set: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> drq);

  a_r9_drq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    drq && done_pulse && !xfer_req |=> !drq);

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load && !host_wr |=> tc_value == $past(tc_load_val));

endmodule

bind pdma_byte_port pdma_byte_port_chk #(
  .DATA_DEPTH (DATA_DEPTH),
  .CMD_DEPTH  (CMD_DEPTH),
  .TCW        (TCW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_mode    (cmd_mode),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .acc_wide    (acc_wide),
  .tc_load     (tc_load),
  .tc_load_val (tc_load_val),
  .tc_value    (tc_value),
  .xfer_req    (xfer_req),
  .drq         (drq),
  .done_pulse  (done_pulse),
  .data_level  (data_level),
  .cmd_level   (cmd_level)
);

// File: tb/pdma_byte_port_bench.sv
module pdma_byte_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0, acc_wide = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        tc_load = 1'b0;
  logic [23:0] tc_load_val = '0;
  logic [23:0] tc_value;
  logic        xfer_req = 1'b0, drq, done_pulse;
  logic        seq_push = 1'b0, seq_pop = 1'b0;
  logic [7:0]  seq_push_data = '0, seq_pop_data;
  logic [4:0]  data_level;
  logic [5:0]  cmd_level;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pdma_byte_port u_pdma_byte_port (
    .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode), .wr_en(wr_en), .rd_en(rd_en),
    .acc_wide(acc_wide), .wr_data(wr_data), .rd_data(rd_data), .tc_load(tc_load),
    .tc_load_val(tc_load_val), .tc_value(tc_value), .xfer_req(xfer_req), .drq(drq),
    .done_pulse(done_pulse), .seq_push(seq_push), .seq_push_data(seq_push_data),
    .seq_pop(seq_pop), .seq_pop_data(seq_pop_data), .data_level(data_level),
    .cmd_level(cmd_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic load_tc(input logic [23:0] v);
    tc_load = 1'b1; tc_load_val = v;
    tick();
    tc_load = 1'b0;
  endtask

  task automatic host_wr(input logic wide, input logic [15:0] d);
    wr_en = 1'b1; acc_wide = wide; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic wide);
    rd_en = 1'b1; acc_wide = wide;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic sq_push(input logic [7:0] b);
    seq_push = 1'b1; seq_push_data = b;
    tick();
    seq_push = 1'b0;
  endtask

  task automatic sq_pop(output logic [7:0] b);
    b = seq_pop_data;
    seq_pop = 1'b1;
    tick();
    seq_pop = 1'b0;
  endtask

  // {tc_init[24], wide, cmd, data[16], exp_tc[24], exp_level[6], exp_done}
  localparam logic [72:0] VEC [6] = '{
    {24'd10,  1'b0, 1'b0, 16'h00A5, 24'd9,   6'd1, 1'b0},
    {24'd10,  1'b1, 1'b0, 16'h1234, 24'd8,   6'd2, 1'b0},
    {24'd1,   1'b1, 1'b1, 16'hBEEF, 24'd0,   6'd1, 1'b1},
    {24'd0,   1'b0, 1'b0, 16'h0077, 24'd0,   6'd0, 1'b1},
    {24'd2,   1'b1, 1'b1, 16'hC3D4, 24'd0,   6'd2, 1'b1},
    {24'h100, 1'b1, 1'b0, 16'h55AA, 24'hFE,  6'd2, 1'b0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    do_reset();

    // R11 reset state
    chk("R11 tc", 32'(tc_value), 0);
    chk("R11 levels", {26'd0, cmd_level} + 32'(data_level), 0);
    chk("R11 drq/done", {30'd0, drq, done_pulse}, 0);
    chk("R11 rd_data", 32'(rd_data), 0);

    // R1 R2 R3 R4 R5: write vectors
    for (int i = 0; i < 6; i++) begin
      logic [23:0] tci, etc;
      logic        w, m, ed;
      logic [15:0] d;
      logic [5:0]  el, lvl;
      {tci, w, m, d, etc, el, ed} = VEC[i];
      do_reset();
      cmd_mode = m;
      load_tc(tci);
      host_wr(w, d);
      lvl = m ? cmd_level : {1'b0, data_level};
      chk("R1 R2 R3 tc after write", 32'(tc_value), 32'(etc));
      chk("R4 level of selected FIFO", 32'(lvl), 32'(el));
      chk("R5 done after write", 32'(done_pulse), 32'(ed));
      if (el != 0) begin
        sq_pop(b);
        chk("R2 first byte", 32'(b), w ? 32'(d[15:8]) : 32'(d[7:0]));
      end
      if (el == 2) begin
        sq_pop(b);
        chk("R2 second byte", 32'(b), 32'(d[7:0]));
      end
      cmd_mode = 1'b0;
    end

    // R4: command-mode write leaves data FIFO untouched
    do_reset();
    cmd_mode = 1'b1;
    load_tc(24'd4);
    host_wr(1'b1, 16'hABCD);
    chk("R4 data FIFO untouched", 32'(data_level), 0);
    host_rd(1'b1);
    chk("R4 R6 cmd read pair", 32'(rd_data), 32'hABCD);
    chk("R7 done when data FIFO empty", 32'(done_pulse), 1);
    cmd_mode = 1'b0;

    // R5 R8: fill data FIFO, overflow drops byte but counter counts
    do_reset();
    load_tc(24'd40);
    for (int k = 0; k < 16; k++) begin
      host_wr(1'b0, 16'(k + 8'h40));
      if (k < 15) chk("R5 no done before full", 32'(done_pulse), 0);
    end
    chk("R5 done on full", 32'(done_pulse), 1);
    host_wr(1'b0, 16'h00EE);
    chk("R8 full drop level", 32'(data_level), 16);
    chk("R8 counter still steps", 32'(tc_value), 23);
    sq_pop(b);
    chk("R8 oldest byte kept", 32'(b), 32'h40);

    // R6 R7 R8: reads
    do_reset();
    sq_push(8'h11); sq_push(8'h22); sq_push(8'h33);
    host_rd(1'b1);
    chk("R6 pair read", 32'(rd_data), 32'h1122);
    chk("R7 no done while bytes remain", 32'(done_pulse), 0);
    host_rd(1'b0);
    chk("R6 narrow read", 32'(rd_data), 32'h0033);
    chk("R7 done on empty", 32'(done_pulse), 1);
    host_rd(1'b1);
    chk("R8 empty pop yields zero", 32'(rd_data), 0);
    tick();
    chk("R7 pulse lasts one cycle", 32'(done_pulse), 0);

    // R9: data request
    do_reset();
    xfer_req = 1'b1; tick(); xfer_req = 1'b0;
    chk("R9 drq set", 32'(drq), 1);
    load_tc(24'd1);
    host_wr(1'b0, 16'h0001);
    chk("R9 drq held during pulse", {30'd0, drq, done_pulse}, 3);
    tick();
    chk("R9 drq cleared", 32'(drq), 0);

    // R10: load ignored during write; seq push ignored during host read
    do_reset();
    load_tc(24'd5);
    tc_load = 1'b1; tc_load_val = 24'd100;
    host_wr(1'b0, 16'h0009);
    tc_load = 1'b0;
    chk("R10 load loses to write", 32'(tc_value), 4);
    sq_pop(b);
    seq_push = 1'b1; seq_push_data = 8'h77;
    host_rd(1'b0);
    seq_push = 1'b0;
    chk("R10 seq push ignored", 32'(data_level), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule